// File: doc/BRIEF.md
# Flash Erase Command Controller

This block models the command side of a byte-wide parallel flash. The host drives single-cycle bus writes (`we`, `addr`, `wdata`) and single-cycle reads (`rd_en`, `addr`). Both erase commands take six writes: an unlock pair, a set-up code, a second unlock pair and the erase code. Any write that does not match the step it lands on drops the decoder back to array reading.

A chip erase starts the embedded erase at once. A sector erase opens an accumulation window instead. During the window, further `0x30` writes queue more sectors and restart the window. Any other write abandons the whole operation. When the window expires, the embedded erase runs in two timed phases. The first drives every targeted byte to `0x00`, and the second sets those bytes to `0xFF`. While the erase runs, writes are ignored and reads return a status byte instead of array data. The storage is a small behavioural register array. At reset it holds a computed pattern.

States: `ST_READ` (array reads), then `ST_UNLK1`, `ST_UNLK2`, `ST_SETUP`, `ST_UNLK3` and `ST_UNLK4`, each reached by the matching command write. After them come `ST_WINDOW`, `ST_PREPROG` and `ST_ERASE`. The transitions are:
- `ST_UNLK4` goes to `ST_PREPROG` on chip erase, or to `ST_WINDOW` on sector erase.
- `ST_WINDOW` goes to `ST_READ` on a foreign write, or to `ST_PREPROG` when its counter expires.
- `ST_PREPROG` goes to `ST_ERASE` when its count ends.
- `ST_ERASE` goes to `ST_READ` when its count ends.
- Any unlock state goes to `ST_READ` on a mismatched write.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset `dout_vld` is 0. A read at edge N gives `dout` and `dout_vld`=1 after edge N, and `dout_vld`=0 after a cycle without a read. In read mode a byte at address a reads `a[7:0] ^ 0x5A` until it is erased.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 erase every sector to 0xFF.
- R3: The same first five writes, followed by 0x30 written to any address, queue the sector given by address bits [10:8]. Only queued sectors become 0xFF; all other bytes keep their contents.
- R4: The sector window stays open for WIN_CYC edges after the last 0x30 write. Reads at edges T+1..T+WIN_CYC show status bit 3 = 0, and later reads show 1. A 0x30 write inside the window queues one more sector and restarts the count.
- R5: A write with data other than 0x30 inside the window returns the block to read mode with the next edge. Nothing is erased, and the queued sectors are dropped, so a later erase leaves them intact.
- R6: A write with a wrong address or wrong data at any of the six steps returns the block to read mode. Nothing is erased.
- R7: From the window's expiry (or a chip erase code) until completion, every write is ignored, including a full new command sequence.
- R8: While busy, a read returns bit 7 = 0 and bit 6 = toggle; bits 5, 4, 2, 1 and 0 are all 0. The toggle is 0 on the first status read after the sixth write and inverts on each further status read.
- R9: With the sixth write (chip) or last 0x30 write (sector) at edge T, status is returned up to edge T+PRE_CYC+ERS_CYC (chip) or T+WIN_CYC+PRE_CYC+ERS_CYC (sector). The erased data is read from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| we | input | 1 | Bus write cycle strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address for writes and reads |
| wdata | input | 8 | Write data / command code |
| dout | output | 8 | Array byte or status byte |
| dout_vld | output | 1 | `dout` holds the result of the previous cycle's read |

## Verification
Every read result is due exactly one edge after the read strobe, so the monitor compares a queued expectation on the falling edge that follows. The driver counts edges itself. It places reads at exact offsets from the last command write: T+WIN_CYC and T+WIN_CYC+1 bracket the window's close, and the last busy edge and the one after it bracket completion. Expected status bytes come from the requirement rules for bit 3 and the toggle, not from design state.

// File: rtl/fec_pkg.sv
package fec_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK1,
        ST_UNLK2,
        ST_SETUP,
        ST_UNLK3,
        ST_UNLK4,
        ST_WINDOW,
        ST_PREPROG,
        ST_ERASE
    } fec_state_e;

    localparam int          CMD_W     = 11;
    localparam logic [10:0] A_FIRST   = 11'h555;
    localparam logic [10:0] A_SECOND  = 11'h2AA;
    localparam logic [7:0]  D_UNLK_A  = 8'hAA;
    localparam logic [7:0]  D_UNLK_B  = 8'h55;
    localparam logic [7:0]  D_SETUP   = 8'h80;
    localparam logic [7:0]  D_CHIP    = 8'h10;
    localparam logic [7:0]  D_SECTOR  = 8'h30;
    localparam logic [7:0]  SEED_MASK = 8'h5A;

    function automatic logic [7:0] status_byte(input logic tgl, input logic closed);
        return {1'b0, tgl, 2'b00, closed, 3'b000};
    endfunction

endpackage

// File: rtl/fec_cmd_fsm.sv
module fec_cmd_fsm
    import fec_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int SEC_W   = 3,
    parameter int WIN_CYC = 12500,
    parameter int PRE_CYC = 200,
    parameter int ERS_CYC = 400,
    parameter int CNT_W   = 15,
    localparam int SEC_N  = 1 << SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output fec_state_e        st,
    output logic [CNT_W-1:0]  cnt,
    output logic [SEC_N-1:0]  sec_mask,
    output logic              busy,
    output logic              win_closed,
    output logic              tgl_clr,
    output logic              fill_en,
    output logic [7:0]        fill_val
);

    fec_state_e        st_n;
    logic [CNT_W-1:0]  cnt_n;
    logic [SEC_N-1:0]  mask_n;
    logic [SEC_N-1:0]  sec_bit;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                                 input logic [10:0] ea, input logic [7:0] ed);
        return (a[CMD_W-1:0] == ea) && (d == ed);
    endfunction

    assign sec_bit = SEC_N'(1) << addr[ADDR_W-1 -: SEC_W];

    // next-state and datapath decisions
    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        mask_n   = sec_mask;
        tgl_clr  = 1'b0;
        fill_en  = 1'b0;
        fill_val = 8'h00;
        unique case (st)
            ST_READ:  if (we && hit(addr, wdata, A_FIRST, D_UNLK_A)) st_n = ST_UNLK1;
            ST_UNLK1: if (we) st_n = hit(addr, wdata, A_SECOND, D_UNLK_B) ? ST_UNLK2 : ST_READ;
            ST_UNLK2: if (we) st_n = hit(addr, wdata, A_FIRST, D_SETUP)   ? ST_SETUP : ST_READ;
            ST_SETUP: if (we) st_n = hit(addr, wdata, A_FIRST, D_UNLK_A)  ? ST_UNLK3 : ST_READ;
            ST_UNLK3: if (we) st_n = hit(addr, wdata, A_SECOND, D_UNLK_B) ? ST_UNLK4 : ST_READ;
            ST_UNLK4: begin
                if (we) begin
                    if (hit(addr, wdata, A_FIRST, D_CHIP)) begin
                        st_n    = ST_PREPROG;
                        mask_n  = '1;
                        cnt_n   = CNT_W'(PRE_CYC - 1);
                        tgl_clr = 1'b1;
                    end else if (wdata == D_SECTOR) begin
                        st_n    = ST_WINDOW;
                        mask_n  = sec_bit;
                        cnt_n   = CNT_W'(WIN_CYC - 1);
                        tgl_clr = 1'b1;
                    end else begin
                        st_n    = ST_READ;
                    end
                end
            end
            ST_WINDOW: begin
                if (we) begin
                    if (wdata == D_SECTOR) begin
                        mask_n = sec_mask | sec_bit;
                        cnt_n  = CNT_W'(WIN_CYC - 1);
                    end else begin
                        st_n   = ST_READ;
                        mask_n = '0;
                    end
                end else if (cnt == '0) begin
                    st_n  = ST_PREPROG;
                    cnt_n = CNT_W'(PRE_CYC - 1);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_PREPROG: begin
                if (cnt == '0) begin
                    fill_en  = 1'b1;
                    fill_val = 8'h00;
                    st_n     = ST_ERASE;
                    cnt_n    = CNT_W'(ERS_CYC - 1);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_ERASE: begin
                if (cnt == '0) begin
                    fill_en  = 1'b1;
                    fill_val = 8'hFF;
                    st_n     = ST_READ;
                    mask_n   = '0;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: begin
                st_n   = ST_READ;
                mask_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_READ;
            cnt      <= '0;
            sec_mask <= '0;
        end else begin
            st       <= st_n;
            cnt      <= cnt_n;
            sec_mask <= mask_n;
        end
    end

    // state-derived outputs
    always_comb begin
        busy       = (st == ST_WINDOW) || (st == ST_PREPROG) || (st == ST_ERASE);
        win_closed = (st == ST_PREPROG) || (st == ST_ERASE);
    end

endmodule

// File: rtl/fec_array.sv
module fec_array
    import fec_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int SEC_W   = 3,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int SEC_N  = 1 << SEC_W,
    localparam int SEC_SZ = DEPTH / SEC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [7:0]        fill_val,
    input  logic [SEC_N-1:0]  fill_mask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rbyte
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ SEED_MASK;
        end else if (fill_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (fill_mask[i / SEC_SZ]) mem[i] <= fill_val;
            end
        end
    end

    assign rbyte = mem[raddr];

endmodule

// File: rtl/fec_status.sv
module fec_status
    import fec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       busy,
    input  logic       win_closed,
    input  logic       tgl_clr,
    input  logic [7:0] arr_byte,
    output logic [7:0] dout,
    output logic       dout_vld
);

    logic tgl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl      <= 1'b0;
            dout     <= 8'h00;
            dout_vld <= 1'b0;
        end else begin
            if (tgl_clr)             tgl <= 1'b0;
            else if (rd_en && busy)  tgl <= ~tgl;
            dout_vld <= rd_en;
            if (rd_en) dout <= busy ? status_byte(tgl, win_closed) : arr_byte;
        end
    end

endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
    import fec_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int SEC_W   = 3,
    parameter int WIN_CYC = 12500,
    parameter int PRE_CYC = 200,
    parameter int ERS_CYC = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        dout,
    output logic              dout_vld
);

    localparam int SEC_N = 1 << SEC_W;
    localparam int MAX_A = (WIN_CYC > PRE_CYC) ? WIN_CYC : PRE_CYC;
    localparam int MAX_C = (MAX_A > ERS_CYC) ? MAX_A : ERS_CYC;
    localparam int CNT_W = $clog2(MAX_C) + 1;

    fec_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [SEC_N-1:0] sec_mask;
    logic             busy, win_closed, tgl_clr, fill_en;
    logic [7:0]       fill_val, arr_byte;

    fec_cmd_fsm #(
        .ADDR_W(ADDR_W), .SEC_W(SEC_W), .WIN_CYC(WIN_CYC),
        .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .st(st), .cnt(cnt), .sec_mask(sec_mask), .busy(busy),
        .win_closed(win_closed), .tgl_clr(tgl_clr),
        .fill_en(fill_en), .fill_val(fill_val)
    );

    fec_array #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_array (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_val(fill_val),
        .fill_mask(sec_mask), .raddr(addr), .rbyte(arr_byte)
    );

    fec_status u_status (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy),
        .win_closed(win_closed), .tgl_clr(tgl_clr), .arr_byte(arr_byte),
        .dout(dout), .dout_vld(dout_vld)
    );

endmodule

// File: rtl/flash_erase_ctl_chk.sv
module flash_erase_ctl_chk
    import fec_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int SEC_N  = 8,
    parameter int CNT_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        dout,
    input logic              dout_vld,
    input fec_state_e        st,
    input logic [CNT_W-1:0]  cnt,
    input logic [SEC_N-1:0]  sec_mask
);

    p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> dout_vld);

    p_chip_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UNLK4 && we && addr[10:0] == A_FIRST && wdata == D_CHIP)
        |=> (st == ST_PREPROG && (&sec_mask)));

    p_window_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WINDOW && !we && cnt == '0) |=> st == ST_PREPROG);

    p_window_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_WINDOW) |=> (dout_vld && !dout[3]));

    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WINDOW && we && wdata != D_SECTOR)
        |=> (st == ST_READ && sec_mask == '0));

    p_bad_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UNLK1 && we && !(addr[10:0] == A_SECOND && wdata == D_UNLK_B))
        |=> st == ST_READ);

    p_mask_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PREPROG) |=> $stable(sec_mask));

    p_status_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st == ST_PREPROG || st == ST_ERASE))
        |=> (!dout[7] && dout[3] && dout[5:4] == 2'b00 && dout[2:0] == 3'b000));

endmodule

bind flash_erase_ctl flash_erase_ctl_chk #(
    .ADDR_W(ADDR_W), .SEC_N(SEC_N), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .we(we), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .dout(dout), .dout_vld(dout_vld), .st(st), .cnt(cnt),
    .sec_mask(sec_mask)
);

// File: tb/test_flash_erase_ctl.sv
module test_flash_erase_ctl;

    localparam int AW  = 11;
    localparam int WIN = 40;
    localparam int PRE = 20;
    localparam int ERS = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    dout;
    logic          dout_vld;

    int checks = 0;
    int errors = 0;
    int edge_no = 0;
    bit exp_tgl = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    flash_erase_ctl #(
        .ADDR_W(AW), .SEC_W(3), .WIN_CYC(WIN), .PRE_CYC(PRE), .ERS_CYC(ERS)
    ) i_flash_erase_ctl (
        .clk(clk), .rst_n(rst_n), .we(we), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .dout(dout), .dout_vld(dout_vld)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic note_fail(input string tag, input logic [7:0] got, input logic [7:0] exp);
        errors++;
        $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    endtask

    task automatic idle();
        @(negedge clk);
        we = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        edge_no++;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
        @(posedge clk);
        edge_no++;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        it.val = e; it.tag = tag;
        q.push_back(it);
        we = 1'b0; rd_en = 1'b1; addr = a;
        @(posedge clk);
        edge_no++;
    endtask

    task automatic rd_st(input logic closed, input string tag);
        logic [7:0] e;
        e = {1'b0, exp_tgl, 2'b00, closed, 3'b000};
        exp_tgl = ~exp_tgl;
        rd('0, e, tag);
    endtask

    task automatic idle_to(input int n);
        while (edge_no < n - 1) idle();
    endtask

    task automatic unlock5();
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
    endtask

    // monitor: compares each result one edge after its read
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dout_vld) begin
                if (q.size() == 0) begin
                    checks++;
                    note_fail("R1 unexpected valid", dout, 8'h00);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    checks++;
                    if (dout !== it.val) note_fail(it.tag, dout, it.val);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        checks++;
        if (dout_vld !== 1'b0) note_fail("R1 reset valid", {7'd0, dout_vld}, 8'h00);
        rst_n = 1'b1;
        edge_no = 0;

        // R1: initial contents
        rd(11'h000, pat(11'h000), "R1 read 000");
        rd(11'h7FF, pat(11'h7FF), "R1 read 7FF");
        rd(11'h123, pat(11'h123), "R1 read 123");
        idle();
        idle();
        checks++;
        if (dout_vld !== 1'b0) note_fail("R1 valid drops", {7'd0, dout_vld}, 8'h00);

        // R6: wrong data at step 3, rest of chip sequence ignored
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h81);
        wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
        rd(11'h100, pat(11'h100), "R6 bad setup data");
        // R6: wrong address at step 6
        unlock5();
        wr(11'h554, 8'h10);
        rd(11'h050, pat(11'h050), "R6 bad erase address");
        // R6: wrong address at step 2
        wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h10);
        repeat (PRE + ERS + 4) idle();
        rd(11'h0A0, pat(11'h0A0), "R6 bad unlock address");
        rd(11'h7A0, pat(11'h7A0), "R6 no erase later");

        // R3/R4/R8/R7/R9: sector erase with an added sector
        unlock5();
        wr(11'h100, 8'h30);
        t = edge_no;
        exp_tgl = 1'b0;
        idle_to(t + 10);
        rd_st(1'b0, "R8 window status first");
        wr(11'h600, 8'h30);
        t = edge_no;
        idle_to(t + WIN);
        rd_st(1'b0, "R4 last open edge");
        rd_st(1'b1, "R4 first closed edge");
        unlock5();
        wr(11'h300, 8'h30);
        wr(11'h000, 8'hF0);
        idle_to(t + WIN + PRE + ERS);
        rd_st(1'b1, "R9 last busy edge");
        rd(11'h100, 8'hFF, "R9 data next edge");
        rd(11'h1FF, 8'hFF, "R3 sector1 end");
        rd(11'h6AB, 8'hFF, "R4 added sector6");
        rd(11'h0FF, pat(11'h0FF), "R3 sector0 kept");
        rd(11'h300, pat(11'h300), "R7 sector3 not queued");
        rd(11'h7FF, pat(11'h7FF), "R3 sector7 kept");

        // R5: abort inside window
        unlock5();
        wr(11'h200, 8'h30);
        exp_tgl = 1'b0;
        rd_st(1'b0, "R8 toggle restart");
        wr(11'h000, 8'hF0);
        rd(11'h200, pat(11'h200), "R5 read mode at once");
        repeat (WIN + PRE + ERS + 4) idle();
        rd(11'h210, pat(11'h210), "R5 nothing erased");
        unlock5();
        wr(11'h500, 8'h30);
        t = edge_no;
        exp_tgl = 1'b0;
        idle_to(t + WIN);
        rd_st(1'b0, "R4 single window open");
        rd_st(1'b1, "R4 single window closed");
        idle_to(t + WIN + PRE + ERS + 1);
        rd(11'h500, 8'hFF, "R3 sector5 erased");
        rd(11'h2AA, pat(11'h2AA), "R5 dropped sector2 kept");

        // R2: chip erase
        unlock5();
        wr(11'h555, 8'h10);
        t = edge_no;
        exp_tgl = 1'b0;
        rd_st(1'b1, "R8 chip status first");
        rd_st(1'b1, "R8 chip status toggled");
        wr(11'h123, 8'hF0);
        idle_to(t + PRE + ERS);
        rd_st(1'b1, "R9 chip last busy");
        for (int s = 0; s < 8; s++) begin
            logic [AW-1:0] a;
            a = AW'((s << 8) | 8'h5A);
            rd(a, 8'hFF, "R2 chip erased");
        end
        idle();
        idle();

        done = 1'b1;
        checks++;
        if (q.size() != 0) note_fail("R1 missing results", 8'(q.size()), 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule